// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command interpreter on the device side of a word-wide NOR flash model with an 18-bit address and 16-bit data. It watches bus write cycles on the chip-select and write-enable strobes. It recognises the fixed unlock handshakes that have to come before every command byte, and it turns a completed sequence into a single-clock operation request. The request carries the operation type, the address and the data word. The storage array and the internal program and erase timing sit outside the block, in a behavioural memory owned by the environment.

Two unlock writes (low byte AA, then 55) come first, and a command byte then chooses the path. Word program needs one more cycle that supplies the target. Erase and boot lockout need a second unlock pair followed by a selecting cycle. A separate mode flag switches reads to identification codes. The flag is set by a three-cycle entry command. It is cleared either by a three-cycle exit command or by a lone exit byte written to any address. While the environment reports that an internal operation is running, every write is discarded.

The strobes are taken as synchronous to `clk`. A write cycle lasts while both strobes are low.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After a synchronous active-low reset, `op_valid` and `id_mode` are 0 and the decoder waits for the first unlock write.
- R2: Command matching looks only at data bits 7..0 and address bits 14..0. Bits 15..8 of the data and bits 17..15 of the address never change the decoding.
- R3: The sequence AA@5555, 55@2AAA, A0@5555 followed by one write of (A, D) issues a program request (`op_kind`=1) with `op_addr`=A and `op_data`=D.
- R4: The sequence AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, 10@5555 issues a chip erase request (`op_kind`=2).
- R5: The same five-cycle prefix followed by 30 at any address S issues a sector erase request (`op_kind`=3) with `op_addr`=S.
- R6: The same five-cycle prefix followed by 40@5555 issues a boot lockout request (`op_kind`=4).
- R7: AA@5555, 55@2AAA, 90@5555 sets `id_mode`. While it is set, `id_rdata` is 001F when `bus_addr[0]`=0 and 0092 when `bus_addr[0]`=1, whatever the other address bits hold. While it is clear, `id_rdata` is 0000.
- R8: `id_mode` is cleared by AA@5555, 55@2AAA, F0@5555, and also by a single write whose low byte is F0 to any address, made while no sequence is in progress.
- R9: A write cycle counts only while both `bus_cs_n` and `bus_we_n` are low. Its address is taken when the second of the two strobes falls. Its data is taken when the first of the two rises.
- R10: A write that does not match the expected step of a sequence sends the decoder back to idle without a request. A full sequence that follows then works normally.
- R11: A write that completes while `busy`=1 is ignored completely. The sequence position and `id_mode` stay as they were, and no request is issued.
- R12: Each request is a pulse on `op_valid` that lasts exactly one clock, with `op_kind` not 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_we_n | input | 1 | Write enable, active low |
| bus_addr | input | 18 | Word address |
| bus_wdata | input | 16 | Write data |
| busy | input | 1 | Internal program or erase in progress |
| op_valid | output | 1 | One-clock operation request |
| op_kind | output | 3 | 1 program, 2 chip erase, 3 sector erase, 4 boot lockout |
| op_addr | output | 18 | Address of the final write of the sequence |
| op_data | output | 16 | Data of the final write of the sequence |
| id_mode | output | 1 | Identification read mode active |
| id_rdata | output | 16 | Identification code for the current address |

## Verification
If the sequence position is wrong, it shows at the ports as a missing, extra or mistyped request two clocks after the strobe that ends the final write. The bench counts every `op_valid` pulse, so a stray request from a broken or ignored sequence is caught as well as a missing one. A wrong mode flag shows at once on `id_rdata` after the entry or exit write. Mid-sequence garbage, busy writes and writes with chip-select high are followed by a completing sequence, so a corrupted position shows up as a lost request.

// File: rtl/flash_cmd_pkg.sv
// Shared types and constants for the flash command decoder.
// Assumes 16-bit data and a 15-bit compare window on command addresses.
package flash_cmd_pkg;
    localparam int CMP_ADDR_W = 15;
    localparam logic [CMP_ADDR_W-1:0] KEY_ADDR_A = 15'h5555;
    localparam logic [CMP_ADDR_W-1:0] KEY_ADDR_B = 15'h2AAA;
    localparam logic [7:0] KEY_BYTE_A  = 8'hAA;
    localparam logic [7:0] KEY_BYTE_B  = 8'h55;
    localparam logic [7:0] CMD_PROG    = 8'hA0;
    localparam logic [7:0] CMD_EXTEND  = 8'h80;
    localparam logic [7:0] CMD_ID_IN   = 8'h90;
    localparam logic [7:0] CMD_ID_OUT  = 8'hF0;
    localparam logic [7:0] SEL_CHIP    = 8'h10;
    localparam logic [7:0] SEL_SECTOR  = 8'h30;
    localparam logic [7:0] SEL_LOCK    = 8'h40;

    typedef enum logic [2:0] {
        OP_NONE         = 3'd0,
        OP_PROGRAM      = 3'd1,
        OP_CHIP_ERASE   = 3'd2,
        OP_SECTOR_ERASE = 3'd3,
        OP_BOOT_LOCK    = 3'd4
    } op_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_KEY1  = 3'd1,
        ST_KEY2  = 3'd2,
        ST_PWORD = 3'd3,
        ST_EXT1  = 3'd4,
        ST_EXT2  = 3'd5,
        ST_SEL   = 3'd6
    } seq_state_e;
endpackage

// File: rtl/flash_bus_capture.sv
// Bus write cycle capture.
// Turns a strobe pair into one completed write: the address is latched when the
// second strobe falls, the data when the first strobe rises. A write counts only
// while both strobes are low. Assumes strobes are synchronous to clk.
module flash_bus_capture #(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              cyc_valid,
    output logic [ADDR_W-1:0] cyc_addr,
    output logic [DATA_W-1:0] cyc_data
);
    logic wr_act;
    logic wr_act_q;

    // Write window: open only while both strobes are active.
    assign wr_act = ~cs_n & ~we_n;

    // Edge tracking plus address/data latching at window open/close.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_act_q  <= 1'b0;
            cyc_valid <= 1'b0;
            cyc_addr  <= '0;
            cyc_data  <= '0;
        end else begin
            wr_act_q  <= wr_act;
            cyc_valid <= wr_act_q & ~wr_act;
            if (wr_act && !wr_act_q)
                cyc_addr <= addr;
            if (wr_act_q && !wr_act)
                cyc_data <= wdata;
        end
    end

    AST_CYC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_valid |=> !cyc_valid); // R9
endmodule

// File: rtl/flash_seq_fsm.sv
// Command sequence state machine.
// Walks the unlock steps, dispatches operation requests as one-clock pulses and
// keeps the identification mode flag. Assumes at most one completed write per
// two clocks (guaranteed by the capture stage).
module flash_seq_fsm
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_valid,
    input  logic [ADDR_W-1:0] cyc_addr,
    input  logic [DATA_W-1:0] cyc_data,
    input  logic              busy,
    output logic              op_valid,
    output op_kind_e          op_kind,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data,
    output logic              id_mode
);
    seq_state_e state, nxt_state;
    logic       nxt_id;
    logic       issue;
    op_kind_e   issue_kind;
    logic       at_key_a, at_key_b;
    logic [7:0] cbyte;

    // Decode the compare windows of the completed write.
    assign at_key_a = (cyc_addr[CMP_ADDR_W-1:0] == KEY_ADDR_A);
    assign at_key_b = (cyc_addr[CMP_ADDR_W-1:0] == KEY_ADDR_B);
    assign cbyte    = cyc_data[7:0];

    // Next sequence step, mode flag and request selection.
    always_comb begin
        nxt_state  = state;
        nxt_id     = id_mode;
        issue      = 1'b0;
        issue_kind = OP_NONE;
        if (cyc_valid && !busy) begin
            nxt_state = ST_IDLE;
            case (state)
                ST_IDLE: begin
                    if (at_key_a && cbyte == KEY_BYTE_A)
                        nxt_state = ST_KEY1;
                    else if (cbyte == CMD_ID_OUT)
                        nxt_id = 1'b0;
                end
                ST_KEY1: if (at_key_b && cbyte == KEY_BYTE_B) nxt_state = ST_KEY2;
                ST_KEY2: begin
                    if (at_key_a) begin
                        case (cbyte)
                            CMD_PROG:   nxt_state = ST_PWORD;
                            CMD_EXTEND: nxt_state = ST_EXT1;
                            CMD_ID_IN:  nxt_id = 1'b1;
                            CMD_ID_OUT: nxt_id = 1'b0;
                            default:    nxt_state = ST_IDLE;
                        endcase
                    end
                end
                ST_PWORD: begin
                    issue      = 1'b1;
                    issue_kind = OP_PROGRAM;
                end
                ST_EXT1: if (at_key_a && cbyte == KEY_BYTE_A) nxt_state = ST_EXT2;
                ST_EXT2: if (at_key_b && cbyte == KEY_BYTE_B) nxt_state = ST_SEL;
                ST_SEL: begin
                    if (at_key_a && cbyte == SEL_CHIP) begin
                        issue = 1'b1; issue_kind = OP_CHIP_ERASE;
                    end else if (cbyte == SEL_SECTOR) begin
                        issue = 1'b1; issue_kind = OP_SECTOR_ERASE;
                    end else if (at_key_a && cbyte == SEL_LOCK) begin
                        issue = 1'b1; issue_kind = OP_BOOT_LOCK;
                    end
                end
                default: nxt_state = ST_IDLE;
            endcase
        end
    end

    // Register state, mode and the request pulse with its payload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            id_mode  <= 1'b0;
            op_valid <= 1'b0;
            op_kind  <= OP_NONE;
            op_addr  <= '0;
            op_data  <= '0;
        end else begin
            state    <= nxt_state;
            id_mode  <= nxt_id;
            op_valid <= issue;
            op_kind  <= issue_kind;
            if (issue) begin
                op_addr <= cyc_addr;
                op_data <= cyc_data;
            end
        end
    end

    AST_OP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> !op_valid); // R12
    AST_OP_KIND_SET: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> (op_kind != OP_NONE)); // R12
    AST_OP_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> $past(cyc_valid && !busy)); // R11
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && busy) |=> ($stable(state) && $stable(id_mode) && !op_valid)); // R11
    AST_IDLE_AFTER_OP: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> (state == ST_IDLE)); // R10
endmodule

// File: rtl/flash_cmd_decoder.sv
// Flash command decoder top.
// Connects the write capture stage to the sequence machine and produces the
// identification read word. Assumes bus strobes are synchronous to clk.
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int          ADDR_W   = 18,
    parameter int          DATA_W   = 16,
    parameter logic [15:0] MFR_CODE = 16'h001F,
    parameter logic [15:0] DEV_CODE = 16'h0092
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs_n,
    input  logic              bus_we_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              busy,
    output logic              op_valid,
    output logic [2:0]        op_kind,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data,
    output logic              id_mode,
    output logic [DATA_W-1:0] id_rdata
);
    localparam int CODE_W = (DATA_W < 16) ? DATA_W : 16;

    logic              cyc_valid;
    logic [ADDR_W-1:0] cyc_addr;
    logic [DATA_W-1:0] cyc_data;
    op_kind_e          kind_int;

    flash_bus_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (bus_cs_n),
        .we_n      (bus_we_n),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .cyc_valid (cyc_valid),
        .cyc_addr  (cyc_addr),
        .cyc_data  (cyc_data)
    );

    flash_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_valid (cyc_valid),
        .cyc_addr  (cyc_addr),
        .cyc_data  (cyc_data),
        .busy      (busy),
        .op_valid  (op_valid),
        .op_kind   (kind_int),
        .op_addr   (op_addr),
        .op_data   (op_data),
        .id_mode   (id_mode)
    );

    assign op_kind = kind_int;

    // Identification word: only address bit 0 selects the code.
    always_comb begin
        id_rdata = '0;
        if (id_mode)
            id_rdata[CODE_W-1:0] = bus_addr[0] ? DEV_CODE[CODE_W-1:0] : MFR_CODE[CODE_W-1:0];
    end
endmodule

// File: tb/test_flash_cmd_decoder.sv
`timescale 1ns/1ps
module test_flash_cmd_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_cs_n = 1'b1;
    logic        bus_we_n = 1'b1;
    logic [17:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        busy = 1'b0;
    logic        op_valid;
    logic [2:0]  op_kind;
    logic [17:0] op_addr;
    logic [15:0] op_data;
    logic        id_mode;
    logic [15:0] id_rdata;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    int mon_cnt = 0;
    logic [2:0]  mon_kind;
    logic [17:0] mon_addr;
    logic [15:0] mon_data;

    always #2 clk = ~clk;

    flash_cmd_decoder i_flash_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_we_n(bus_we_n),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .busy(busy),
        .op_valid(op_valid), .op_kind(op_kind), .op_addr(op_addr),
        .op_data(op_data), .id_mode(id_mode), .id_rdata(id_rdata)
    );

    // Request monitor: counts every clock in which op_valid is high.
    always @(negedge clk) begin
        if (rst_n && op_valid) begin
            mon_cnt  <= mon_cnt + 1;
            mon_kind <= op_kind;
            mon_addr <= op_addr;
            mon_data <= op_data;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One bus write; cs_lead picks which strobe falls first. Address is scrambled
    // after the window opens, data after the first strobe rises (R9).
    task automatic bus_write(input logic [17:0] a, input logic [15:0] d, input bit cs_lead);
        @(negedge clk);
        bus_addr = a;
        if (cs_lead) bus_cs_n = 1'b0; else bus_we_n = 1'b0;
        @(negedge clk);
        if (cs_lead) bus_we_n = 1'b0; else bus_cs_n = 1'b0;
        @(negedge clk);
        bus_addr  = 18'($urandom);
        bus_wdata = d;
        @(negedge clk);
        if (cs_lead) bus_we_n = 1'b1; else bus_cs_n = 1'b1;
        @(negedge clk);
        bus_wdata = 16'($urandom);
        if (cs_lead) bus_cs_n = 1'b1; else bus_we_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [17:0] key_a();
        return {3'($urandom), 15'h5555};
    endfunction
    function automatic logic [17:0] key_b();
        return {3'($urandom), 15'h2AAA};
    endfunction
    function automatic logic [15:0] bytew(input logic [7:0] b);
        return {8'($urandom), b};
    endfunction

    task automatic unlock();
        bus_write(key_a(), bytew(8'hAA), 1'($urandom));
        bus_write(key_b(), bytew(8'h55), 1'($urandom));
    endtask

    task automatic erase_prefix();
        unlock();
        bus_write(key_a(), bytew(8'h80), 1'($urandom));
        unlock();
    endtask

    task automatic expect_op(input int base, input logic [2:0] k, input logic [17:0] a,
                             input logic [15:0] d, input bit chk_ad, input string tag);
        check(mon_cnt == base + 1, tag, 32'(mon_cnt - base), 1);
        check(mon_kind == k, tag, 32'(mon_kind), 32'(k));
        if (chk_ad) begin
            check(mon_addr == a, tag, 32'(mon_addr), 32'(a));
            check(mon_data == d, tag, 32'(mon_data), 32'(d));
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        int base;
        logic [17:0] a;
        logic [15:0] d;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(op_valid == 1'b0, "R1 op_valid after reset", 32'(op_valid), 0);
        check(id_mode == 1'b0, "R1 id_mode after reset", 32'(id_mode), 0);
        check(id_rdata == 16'h0000, "R7 id_rdata outside id mode", 32'(id_rdata), 0);

        // R3 directed program, exact addresses
        base = mon_cnt;
        bus_write(18'h05555, 16'h00AA, 1'b0);
        bus_write(18'h02AAA, 16'h0055, 1'b1);
        bus_write(18'h05555, 16'h00A0, 1'b0);
        bus_write(18'h3ABCD, 16'hBEEF, 1'b1);
        expect_op(base, 3'd1, 18'h3ABCD, 16'hBEEF, 1'b1, "R3 program directed");

        // R2 upper address bits and high data byte ignored
        base = mon_cnt;
        bus_write(18'h3D555, 16'hFFAA, 1'b1);
        bus_write(18'h1AAAA, 16'h1255, 1'b0);
        bus_write(18'h2D555, 16'h77A0, 1'b1);
        bus_write(18'h00001, 16'h0000, 1'b0);
        expect_op(base, 3'd1, 18'h00001, 16'h0000, 1'b1, "R2 masked compare");

        // R4 chip erase
        base = mon_cnt;
        erase_prefix();
        bus_write(key_a(), bytew(8'h10), 1'b0);
        expect_op(base, 3'd2, '0, '0, 1'b0, "R4 chip erase");

        // R5 sector erase with sector address
        base = mon_cnt;
        erase_prefix();
        bus_write(18'h05123, 16'h0030, 1'b1);
        expect_op(base, 3'd3, 18'h05123, 16'h0030, 1'b1, "R5 sector erase");

        // R6 boot lockout
        base = mon_cnt;
        erase_prefix();
        bus_write(18'h05555, 16'h0040, 1'b0);
        expect_op(base, 3'd4, 18'h05555, 16'h0040, 1'b1, "R6 boot lockout");

        // R7 identification entry and codes
        unlock();
        bus_write(key_a(), bytew(8'h90), 1'b1);
        check(id_mode == 1'b1, "R7 id_mode set", 32'(id_mode), 1);
        bus_addr = 18'h2F0F0;
        #1;
        check(id_rdata == 16'h001F, "R7 code at A0=0", 32'(id_rdata), 32'h1F);
        bus_addr = 18'h1FFFF;
        #1;
        check(id_rdata == 16'h0092, "R7 code at A0=1", 32'(id_rdata), 32'h92);

        // R8 single-cycle exit at arbitrary address
        bus_write(18'h12345, 16'hABF0, 1'b0);
        check(id_mode == 1'b0, "R8 single exit", 32'(id_mode), 0);
        check(id_rdata == 16'h0000, "R7 id_rdata cleared", 32'(id_rdata), 0);

        // R8 three-cycle exit
        unlock();
        bus_write(key_a(), bytew(8'h90), 1'b0);
        check(id_mode == 1'b1, "R8 re-entry", 32'(id_mode), 1);
        unlock();
        bus_write(key_a(), bytew(8'hF0), 1'b1);
        check(id_mode == 1'b0, "R8 three-cycle exit", 32'(id_mode), 0);

        // R10 mismatch mid-sequence: no op, and then recovery
        base = mon_cnt;
        unlock();
        bus_write(key_a(), bytew(8'h33), 1'b0);
        bus_write(18'h00100, 16'h1111, 1'b1);
        check(mon_cnt == base, "R10 no op after bad command", 32'(mon_cnt - base), 0);
        erase_prefix();
        bus_write(18'h01234, 16'h0055, 1'b0);
        check(mon_cnt == base, "R10 no op after bad select", 32'(mon_cnt - base), 0);
        unlock();
        bus_write(key_a(), bytew(8'hA0), 1'b0);
        bus_write(18'h00200, 16'h2222, 1'b0);
        expect_op(base, 3'd1, 18'h00200, 16'h2222, 1'b1, "R10 recovery");

        // R9 write-enable pulse with chip-select high does not count
        base = mon_cnt;
        unlock();
        @(negedge clk); bus_addr = 18'h00777; bus_wdata = 16'h0000; bus_we_n = 1'b0;
        repeat (3) @(negedge clk); bus_we_n = 1'b1;
        repeat (3) @(negedge clk);
        bus_write(key_a(), bytew(8'hA0), 1'b1);
        bus_write(18'h00300, 16'h3333, 1'b0);
        expect_op(base, 3'd1, 18'h00300, 16'h3333, 1'b1, "R9 strobe qualification");

        // R11 busy writes ignored, sequence position kept
        base = mon_cnt;
        unlock();
        busy = 1'b1;
        bus_write(18'h00999, 16'h9999, 1'b1);
        bus_write(18'h3FFFF, 16'hFFF0, 1'b0);
        busy = 1'b0;
        bus_write(key_a(), bytew(8'hA0), 1'b0);
        bus_write(18'h00400, 16'h4444, 1'b1);
        expect_op(base, 3'd1, 18'h00400, 16'h4444, 1'b1, "R11 busy ignored");
        base = mon_cnt;
        busy = 1'b1;
        unlock();
        bus_write(key_a(), bytew(8'hA0), 1'b0);
        bus_write(18'h00500, 16'h5555, 1'b1);
        busy = 1'b0;
        check(mon_cnt == base, "R11 no op while busy", 32'(mon_cnt - base), 0);

        // R3 R10 R12 random programs, with random garbage before some of them
        for (int i = 0; i < 40; i++) begin
            base = mon_cnt;
            if (i % 2 == 1) begin
                d = 16'($urandom);
                if (d[7:0] == 8'hAA) d[7:0] = 8'h00;
                bus_write(18'($urandom), d, 1'($urandom));
            end
            a = 18'($urandom);
            d = 16'($urandom);
            unlock();
            bus_write(key_a(), bytew(8'hA0), 1'($urandom));
            bus_write(a, d, 1'($urandom));
            expect_op(base, 3'd1, a, d, 1'b1, "R12 random program");
        end

        done = 1'b1;
        finish_run();
    end
endmodule